// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block tracks the operating mode of a small microcontroller and drives the clock gates, regulator state and keep-alive controls that follow from that mode. Configuration bits (debug enable, low-voltage-detect enable, detect-in-stop enable, low-power-run request and partial-power-down select) arrive as plain level inputs. Single-cycle pulses report that the core has executed a WAIT or a STOP instruction. A stop-enable level gates whether STOP is legal. A wake pulse ends a wait or stop period.

The mode is held in one register. Every output is decoded from that register and the live configuration bits. Two guards redirect a requested mode. A deep (partial power-down) stop becomes the lighter stop when debug or voltage detection is enabled. A low-power-run request is ignored while either of them is enabled. Leaving deep stop raises a one-cycle reset request, because the core lost its state.

Top module: `pwr_mode_seq`

## Requirements
- R1: While rst_ni is low, mode_o is 0 (normal run), and illegal_op_o and reset_req_o are 0. Mode codes are 0 run, 1 low-power run, 2 wait, 3 low-power wait, 4 light stop, 5 deep stop. reg_state_o codes are 0 on, 1 standby, 2 partial power-down.
- R2: In normal run, cpu_clk_en_o=1, per_clk_en_o=1, per_clk_slow_o=0, reg_state_o=0, lvd_active_o=lvd_en_i, dbg_clk_en_o=dbg_en_i and rtc_keep_o=0.
- R3: From normal run with lp_run_req_i=1, the mode becomes low-power run one clock later only if dbg_en_i=0 and lvd_en_i=0. Otherwise the request is ignored. Low-power run returns to normal run one clock after the request drops or after debug or detect becomes enabled. In low-power run the clocks run slow and reg_state_o=1.
- R4: A wait_exec_i pulse in normal run enters wait. There cpu_clk_en_o=0, the peripheral clocks run at full speed and the regulator stays on. A wake_i pulse returns to normal run.
- R5: A wait_exec_i pulse in low-power run enters low-power wait. There the CPU clock is off, the peripheral clocks are slow and the regulator is in standby. A wake_i pulse returns to low-power run.
- R6: A stop_exec_i pulse with stop_en_i=1 in either run mode enters deep stop when ppd_sel_i=1, dbg_en_i=0 and lvd_en_i=0. Otherwise it enters light stop.
- R7: In light stop both clock enables are 0. reg_state_o is 0 when dbg_en_i=1 or when lvd_en_i and lvd_stop_en_i are both 1. Otherwise reg_state_o is 1.
- R8: In light stop, lvd_active_o = lvd_en_i & lvd_stop_en_i and dbg_clk_en_o = dbg_en_i.
- R9: In deep stop all clock enables, lvd_active_o and dbg_clk_en_o are 0, reg_state_o=2 and rtc_keep_o=1.
- R10: A wake_i pulse in light stop returns to the run mode the stop was entered from. A wake_i pulse in deep stop enters normal run and sets reset_req_o for exactly one cycle.
- R11: A stop_exec_i pulse with stop_en_i=0 leaves the mode unchanged and sets illegal_op_o for exactly the following cycle.
- R12: When stop_exec_i (with stop_en_i=1) and wait_exec_i arrive in the same cycle, the stop wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dbg_en_i | input | 1 | Debug enable |
| lvd_en_i | input | 1 | Low-voltage-detect enable |
| lvd_stop_en_i | input | 1 | Keep voltage detect alive in stop |
| lp_run_req_i | input | 1 | Low-power run request |
| ppd_sel_i | input | 1 | Select partial power-down for stop |
| stop_en_i | input | 1 | STOP instruction allowed |
| wait_exec_i | input | 1 | WAIT executed (pulse) |
| stop_exec_i | input | 1 | STOP executed (pulse) |
| wake_i | input | 1 | Wake event (pulse) |
| mode_o | output | 3 | Current mode code |
| cpu_clk_en_o | output | 1 | CPU clock gate |
| per_clk_en_o | output | 1 | Peripheral clock gate |
| per_clk_slow_o | output | 1 | Peripheral clocks from low-frequency bypass |
| reg_state_o | output | 2 | Regulator state code |
| lvd_active_o | output | 1 | Voltage detect operating |
| dbg_clk_en_o | output | 1 | Debug clock source enable |
| rtc_keep_o | output | 1 | Hold the RTC domain alive during power-down |
| illegal_op_o | output | 1 | Illegal STOP pulse |
| reset_req_o | output | 1 | Reset request after deep-stop wake |

## Verification
A wrong mode register shows at once on mode_o. It also shows on the next sample through a clock gate or regulator code that disagrees with the configuration. A lost stop origin stays hidden until the wake from light stop, when the block lands in the wrong run mode. The bench sweeps every configuration combination through each entry and wake path. It checks every output one clock after each pulse, so a misrouted entry or wake is visible within that single cycle.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  localparam int unsigned MODE_W = 3;
  localparam int unsigned REG_W  = 2;

  typedef enum logic [MODE_W-1:0] {
    M_RUN    = 3'd0,
    M_LPRUN  = 3'd1,
    M_WAIT   = 3'd2,
    M_LPWAIT = 3'd3,
    M_LSTOP  = 3'd4,
    M_DSTOP  = 3'd5
  } mode_e;

  typedef enum logic [REG_W-1:0] {
    REG_ON  = 2'd0,
    REG_SBY = 2'd1,
    REG_PPD = 2'd2
  } reg_e;
endpackage

// File: rtl/pwr_entry_sel.sv
module pwr_entry_sel
  import pwr_mode_pkg::*;
(
  input  mode_e mode_i,
  input  mode_e origin_i,
  input  logic  dbg_en_i,
  input  logic  lvd_en_i,
  input  logic  lp_run_req_i,
  input  logic  ppd_sel_i,
  input  logic  stop_en_i,
  input  logic  wait_exec_i,
  input  logic  stop_exec_i,
  input  logic  wake_i,
  output mode_e mode_n_o,
  output mode_e origin_n_o,
  output logic  illegal_o,
  output logic  reset_req_o
);
  logic quiet_cfg;  // debug and detect both off
  logic is_run;

  assign quiet_cfg = !dbg_en_i && !lvd_en_i;
  assign is_run    = (mode_i == M_RUN) || (mode_i == M_LPRUN);

  always_comb begin
    mode_n_o    = mode_i;
    origin_n_o  = origin_i;
    illegal_o   = 1'b0;
    reset_req_o = 1'b0;
    unique case (mode_i)
      M_RUN, M_LPRUN: begin
        illegal_o = stop_exec_i && !stop_en_i;
        if (stop_exec_i && stop_en_i) begin
          mode_n_o   = (ppd_sel_i && quiet_cfg) ? M_DSTOP : M_LSTOP;
          origin_n_o = mode_i;
        end else if (wait_exec_i) begin
          mode_n_o = (mode_i == M_LPRUN) ? M_LPWAIT : M_WAIT;
        end else if (mode_i == M_RUN && lp_run_req_i && quiet_cfg) begin
          mode_n_o = M_LPRUN;
        end else if (mode_i == M_LPRUN && !(lp_run_req_i && quiet_cfg)) begin
          mode_n_o = M_RUN;
        end
      end
      M_WAIT:   if (wake_i) mode_n_o = M_RUN;
      M_LPWAIT: if (wake_i) mode_n_o = M_LPRUN;
      M_LSTOP:  if (wake_i) mode_n_o = origin_i;
      M_DSTOP: begin
        if (wake_i) begin
          mode_n_o    = M_RUN;
          reset_req_o = 1'b1;
        end
      end
      default: mode_n_o = M_RUN;
    endcase
  end

  logic unused_run;
  assign unused_run = is_run;
endmodule

// File: rtl/pwr_mode_state.sv
module pwr_mode_state
  import pwr_mode_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  mode_e mode_n_i,
  input  mode_e origin_n_i,
  input  logic  illegal_i,
  input  logic  reset_req_i,
  input  logic  dbg_en_i,
  input  logic  lvd_en_i,
  input  logic  stop_exec_i,
  input  logic  stop_en_i,
  output mode_e mode_o,
  output mode_e origin_o,
  output logic  illegal_o,
  output logic  reset_req_o
);
  mode_e mode_q, origin_q;
  logic  illegal_q, reset_req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q      <= M_RUN;
      origin_q    <= M_RUN;
      illegal_q   <= 1'b0;
      reset_req_q <= 1'b0;
    end else begin
      mode_q      <= mode_n_i;
      origin_q    <= origin_n_i;
      illegal_q   <= illegal_i;
      reset_req_q <= reset_req_i;
    end
  end

  assign mode_o      = mode_q;
  assign origin_o    = origin_q;
  assign illegal_o   = illegal_q;
  assign reset_req_o = reset_req_q;

  AST_LPRUN_GUARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == M_LPRUN && $past(mode_q) == M_RUN) |-> (!$past(dbg_en_i) && !$past(lvd_en_i))); // R3
  AST_DEEP_GUARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == M_DSTOP && $past(mode_q) != M_DSTOP) |-> (!$past(dbg_en_i) && !$past(lvd_en_i))); // R6
  AST_WAKE_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_req_q |-> ($past(mode_q) == M_DSTOP && mode_q == M_RUN)); // R10
  AST_ILLEGAL_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_q |-> ($past(stop_exec_i) && !$past(stop_en_i) && $stable(mode_q))); // R11
  AST_ORIGIN_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (origin_q == M_RUN) || (origin_q == M_LPRUN)); // R10
endmodule

// File: rtl/pwr_out_dec.sv
module pwr_out_dec
  import pwr_mode_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  mode_e mode_i,
  input  logic  dbg_en_i,
  input  logic  lvd_en_i,
  input  logic  lvd_stop_en_i,
  output logic  cpu_clk_en_o,
  output logic  per_clk_en_o,
  output logic  per_clk_slow_o,
  output reg_e  reg_state_o,
  output logic  lvd_active_o,
  output logic  dbg_clk_en_o,
  output logic  rtc_keep_o
);
  logic lvd_in_stop;
  assign lvd_in_stop = lvd_en_i && lvd_stop_en_i;

  always_comb begin
    cpu_clk_en_o   = 1'b0;
    per_clk_en_o   = 1'b0;
    per_clk_slow_o = 1'b0;
    reg_state_o    = REG_ON;
    lvd_active_o   = lvd_en_i;
    dbg_clk_en_o   = dbg_en_i;
    rtc_keep_o     = 1'b0;
    unique case (mode_i)
      M_RUN: begin
        cpu_clk_en_o = 1'b1;
        per_clk_en_o = 1'b1;
      end
      M_LPRUN: begin
        cpu_clk_en_o   = 1'b1;
        per_clk_en_o   = 1'b1;
        per_clk_slow_o = 1'b1;
        reg_state_o    = REG_SBY;
      end
      M_WAIT: per_clk_en_o = 1'b1;
      M_LPWAIT: begin
        per_clk_en_o   = 1'b1;
        per_clk_slow_o = 1'b1;
        reg_state_o    = REG_SBY;
      end
      M_LSTOP: begin
        reg_state_o  = (dbg_en_i || lvd_in_stop) ? REG_ON : REG_SBY;
        lvd_active_o = lvd_in_stop;
      end
      M_DSTOP: begin
        reg_state_o  = REG_PPD;
        lvd_active_o = 1'b0;
        dbg_clk_en_o = 1'b0;
        rtc_keep_o   = 1'b1;
      end
      default: ;
    endcase
  end

  AST_STOP_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == M_LSTOP || mode_i == M_DSTOP) |-> (!cpu_clk_en_o && !per_clk_en_o)); // R7
  AST_PPD_ONLY_DEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_state_o == REG_PPD) |-> (rtc_keep_o && !lvd_active_o && !dbg_clk_en_o)); // R9
  AST_LSTOP_REG_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == M_LSTOP && lvd_active_o) |-> (reg_state_o == REG_ON)); // R8
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pwr_mode_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    dbg_en_i,
  input  logic                    lvd_en_i,
  input  logic                    lvd_stop_en_i,
  input  logic                    lp_run_req_i,
  input  logic                    ppd_sel_i,
  input  logic                    stop_en_i,
  input  logic                    wait_exec_i,
  input  logic                    stop_exec_i,
  input  logic                    wake_i,
  output logic [MODE_W-1:0]       mode_o,
  output logic                    cpu_clk_en_o,
  output logic                    per_clk_en_o,
  output logic                    per_clk_slow_o,
  output logic [REG_W-1:0]        reg_state_o,
  output logic                    lvd_active_o,
  output logic                    dbg_clk_en_o,
  output logic                    rtc_keep_o,
  output logic                    illegal_op_o,
  output logic                    reset_req_o
);
  mode_e mode_q, origin_q, mode_n, origin_n;
  logic  illegal_n, reset_req_n;
  reg_e  reg_state;

  pwr_entry_sel u_sel (
    .mode_i       (mode_q),
    .origin_i     (origin_q),
    .dbg_en_i     (dbg_en_i),
    .lvd_en_i     (lvd_en_i),
    .lp_run_req_i (lp_run_req_i),
    .ppd_sel_i    (ppd_sel_i),
    .stop_en_i    (stop_en_i),
    .wait_exec_i  (wait_exec_i),
    .stop_exec_i  (stop_exec_i),
    .wake_i       (wake_i),
    .mode_n_o     (mode_n),
    .origin_n_o   (origin_n),
    .illegal_o    (illegal_n),
    .reset_req_o  (reset_req_n)
  );

  pwr_mode_state u_state (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_n_i    (mode_n),
    .origin_n_i  (origin_n),
    .illegal_i   (illegal_n),
    .reset_req_i (reset_req_n),
    .dbg_en_i    (dbg_en_i),
    .lvd_en_i    (lvd_en_i),
    .stop_exec_i (stop_exec_i),
    .stop_en_i   (stop_en_i),
    .mode_o      (mode_q),
    .origin_o    (origin_q),
    .illegal_o   (illegal_op_o),
    .reset_req_o (reset_req_o)
  );

  pwr_out_dec u_dec (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .mode_i         (mode_q),
    .dbg_en_i       (dbg_en_i),
    .lvd_en_i       (lvd_en_i),
    .lvd_stop_en_i  (lvd_stop_en_i),
    .cpu_clk_en_o   (cpu_clk_en_o),
    .per_clk_en_o   (per_clk_en_o),
    .per_clk_slow_o (per_clk_slow_o),
    .reg_state_o    (reg_state),
    .lvd_active_o   (lvd_active_o),
    .dbg_clk_en_o   (dbg_clk_en_o),
    .rtc_keep_o     (rtc_keep_o)
  );

  assign mode_o      = mode_q;
  assign reg_state_o = reg_state;

  AST_RESET_REQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_req_o |=> !reset_req_o); // R10
endmodule

// File: tb/pwr_mode_seq_test.sv
module pwr_mode_seq_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic dbg = 0, lvd = 0, lvds = 0, lpreq = 0, ppd = 0, sten = 0;
  logic wt = 0, st = 0, wk = 0;
  logic [2:0] mode;
  logic cpu, per, slow, lvda, dbgc, rtc, ill, rrq;
  logic [1:0] regs;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_mode_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .dbg_en_i(dbg), .lvd_en_i(lvd), .lvd_stop_en_i(lvds),
    .lp_run_req_i(lpreq), .ppd_sel_i(ppd), .stop_en_i(sten), .wait_exec_i(wt),
    .stop_exec_i(st), .wake_i(wk), .mode_o(mode), .cpu_clk_en_o(cpu), .per_clk_en_o(per),
    .per_clk_slow_o(slow), .reg_state_o(regs), .lvd_active_o(lvda), .dbg_clk_en_o(dbgc),
    .rtc_keep_o(rtc), .illegal_op_o(ill), .reset_req_o(rrq));

  // {mode, cpu, per, slow, reg, lvd_active, dbg_clk, rtc}
  function automatic logic [10:0] expect_out(input int m);
    logic c, p, s, la, dc, r;
    logic [1:0] rg;
    c = 0; p = 0; s = 0; rg = 0; la = lvd; dc = dbg; r = 0;
    case (m)
      0: begin c = 1; p = 1; end
      1: begin c = 1; p = 1; s = 1; rg = 1; end
      2: p = 1;
      3: begin p = 1; s = 1; rg = 1; end
      4: begin rg = (dbg || (lvd && lvds)) ? 2'd0 : 2'd1; la = lvd & lvds; end
      default: begin rg = 2; la = 0; dc = 0; r = 1; end
    endcase
    return {3'(m), c, p, s, rg, la, dc, r};
  endfunction

  task automatic check(input string tag, input int m, input logic e_ill, input logic e_rrq);
    logic [12:0] act, exp;
    act = {mode, cpu, per, slow, regs, lvda, dbgc, rtc, ill, rrq};
    exp = {expect_out(m), e_ill, e_rrq};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s cfg d%0d l%0d s%0d p%0d q%0d: act %b exp %b",
               tag, dbg, lvd, lvds, ppd, lpreq, act, exp);
    end
  endtask

  // drive pulses for one clock, sample at the following falling edge
  task automatic cyc(input logic w, input logic s, input logic k);
    wt = w; st = s; wk = k;
    @(negedge clk);
    wt = 0; st = 0; wk = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    for (int c = 0; c < 32; c++) begin
      int base, stp;
      logic quiet;
      rst_n = 0;
      {dbg, lvd, lvds, ppd, lpreq} = 5'(c);
      @(negedge clk);
      check("R1 reset", 0, 0, 0);
      rst_n = 1;
      quiet = !dbg && !lvd;
      base = (lpreq && quiet) ? 1 : 0;
      stp  = (ppd && quiet) ? 5 : 4;
      cyc(0, 0, 0);
      check(base == 1 ? "R3 lprun entry" : "R2 R3 run", base, 0, 0);
      cyc(1, 0, 0);
      check(base == 1 ? "R5 lpwait" : "R4 wait", base + 2, 0, 0);
      cyc(0, 0, 1);
      check(base == 1 ? "R5 wake" : "R4 wake", base, 0, 0);
      sten = 0;
      cyc(0, 1, 0);
      check("R11 illegal", base, 1, 0);
      cyc(0, 0, 0);
      check("R11 one cycle", base, 0, 0);
      sten = 1;
      cyc(0, 1, 0);
      check(stp == 5 ? "R6 R9 deep" : "R6 R7 R8 light", stp, 0, 0);
      cyc(0, 0, 1);
      if (stp == 5) begin
        check("R10 deep wake", 0, 0, 1);
        cyc(0, 0, 0);
        check("R10 pulse end", base, 0, 0);
      end else begin
        check("R10 light wake", base, 0, 0);
      end
      cyc(1, 1, 0);
      check("R12 stop wins", stp, 0, 0);
      cyc(0, 0, 1);
      if (stp == 5) cyc(0, 0, 0);
      check("R12 return", base, 0, 0);
      if (base == 1) begin
        dbg = 1;
        cyc(0, 0, 0);
        check("R3 lprun exit", 0, 0, 0);
        dbg = 0; lpreq = 0;
        cyc(0, 0, 0);
        check("R3 request low", 0, 0, 0);
      end
      sten = 0;
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule